// File: doc/BRIEF.md
# Transmit Packet FIFO with Underflow Abort

This block sits between a link-layer writer and a line-side packet transmitter. The writer presents one byte per cycle, together with an odd-parity bit and start/end-of-packet flags. Those bytes are queued in a small FIFO. The line side takes bytes out of the FIFO one at a time by pulsing a pull request. The block registers each byte on its output one cycle after the pull.

Sometimes the line side asks for a byte while the FIFO is empty and the writer is still partway through a packet. The block treats this as an underflow. It ends the packet on the line side with an abort pulse in place of a normal end marker. It then drops every remaining byte the writer sends for that packet, up to and including the end marker. After that, the next start of packet is accepted normally.

Every written byte is parity checked. Underflows and parity errors are latched in a two-bit status register that clears when read. A matching two-bit enable register gates these bits onto a level interrupt output.

Top module: `txpkt_fifo_abort`

## Requirements
- R1: After reset the FIFO is empty, the tx outputs and irq are 0, and both the status register (address 0) and the enable register (address 1) read 0.
- R2: Accepted bytes leave in write order. When tx_pull is high and the FIFO holds data, the next cycle shows tx_valid=1 with that byte's data, sop flag and eop flag.
- R3: wr_full is 1 while DEPTH bytes are queued. A write made while the FIFO is full is dropped.
- R4: An underflow is a cycle with tx_pull high, the FIFO empty, and a packet open on the write side (a start accepted and its end not yet accepted or discarded). The next cycle shows tx_abort=1 with tx_valid=0. A pull on an empty FIFO with no open packet produces no output.
- R5: After an underflow, every write is discarded up to and including the next write carrying wr_eop. This includes a write in the underflow cycle itself.
- R6: Once the discarded packet's end marker has been seen, a following start-of-packet write is queued and sent normally.
- R7: A write has a parity error when the XOR of wr_data and wr_par is 0, so odd parity is expected. Parity is checked on every wr_valid cycle, including writes that are dropped or discarded.
- R8: A read of address 0 returns {6'b0, underflow, parity_error} in reg_rdata on the next cycle and clears both bits. Each bit stays set until such a read. Writes to address 0 have no effect.
- R9: If an event coincides with a read of address 0, the read returns the value from before the event and the bit remains set afterwards.
- R10: Address 1 holds the enables: bit 1 for underflow and bit 0 for parity. Both bits are writable, and bits 7:2 always read 0.
- R11: irq is 1 exactly when some status bit and its enable bit are both 1.
- R12: In a cycle following one without tx_pull, tx_valid and tx_abort are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte present |
| wr_data | input | DW | Write byte |
| wr_par | input | 1 | Odd parity bit for wr_data |
| wr_sop | input | 1 | Byte starts a packet |
| wr_eop | input | 1 | Byte ends a packet |
| wr_full | output | 1 | FIFO full |
| tx_pull | input | 1 | Line side requests a byte |
| tx_valid | output | 1 | Byte on tx outputs |
| tx_data | output | DW | Transmitted byte |
| tx_sop | output | 1 | Byte starts a packet |
| tx_eop | output | 1 | Byte ends a packet |
| tx_abort | output | 1 | Current packet aborted |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 status, 1 enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after reg_rd |
| irq | output | 1 | Interrupt |

## Verification
Two things can fall in the same cycle: a status read that clears the register, and a new event that sets a bit. The bench provokes this twice. First it drives a bad-parity write in the same cycle as a status read. Then it issues the underflowing pull in the same cycle as a status read. In each case the returned value must lack the new bit, and the following read must show it. A second collision is also covered: a packet byte written in the very cycle the underflow is detected must be discarded rather than queued.

// File: rtl/txpkt_fifo_abort.sv
module txpkt_fifo_abort #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_par,
  input  logic          wr_sop,
  input  logic          wr_eop,
  output logic          wr_full,
  input  logic          tx_pull,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_sop,
  output logic          tx_eop,
  output logic          tx_abort,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pkt_open, drop_q;
  logic [1:0]    sts_q, en_q;

  logic fifo_empty, underflow, accept, pop, par_err, sts_clr;
  wire  unused_wdata = ^reg_wdata[7:2];

  assign fifo_empty = (cnt == '0);
  assign wr_full    = (cnt == CW'(DEPTH));
  assign underflow  = tx_pull & fifo_empty & pkt_open & ~drop_q;
  assign accept     = wr_valid & ~drop_q & ~underflow & ~wr_full;
  assign pop        = tx_pull & ~fifo_empty;
  assign par_err    = wr_valid & ~(^{wr_data, wr_par});
  assign sts_clr    = reg_rd & ~reg_addr;
  assign irq        = |(sts_q & en_q);

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= {wr_sop, wr_eop, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)    rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_open <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      if (underflow) begin
        pkt_open <= 1'b0;
        drop_q   <= ~(wr_valid & wr_eop);
      end else begin
        if (drop_q && wr_valid && wr_eop) drop_q <= 1'b0;
        if (accept) begin
          if (wr_eop)      pkt_open <= 1'b0;
          else if (wr_sop) pkt_open <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_abort <= 1'b0;
      tx_sop   <= 1'b0;
      tx_eop   <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= pop;
      tx_abort <= underflow;
      if (pop) {tx_sop, tx_eop, tx_data} <= mem[rp];
      else     {tx_sop, tx_eop, tx_data} <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q     <= '0;
      en_q      <= '0;
      reg_rdata <= '0;
    end else begin
      sts_q <= (sts_q & ~{2{sts_clr}}) | {underflow, par_err};
      if (reg_wr && reg_addr) en_q <= reg_wdata[1:0];
      if (reg_rd) reg_rdata <= {6'b0, reg_addr ? en_q : sts_q};
    end
  end
endmodule

module txpkt_fifo_abort_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_pull,
  input logic       tx_valid,
  input logic       tx_abort,
  input logic       reg_rd,
  input logic       reg_addr,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic [1:0] sts,
  input logic [1:0] en
);
  AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_abort && tx_valid));                                    // R4
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort);                                     // R4
  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pull |=> (!tx_valid && !tx_abort));                      // R12
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (reg_rdata[7:2] == 6'b0));                        // R10
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !(reg_rd && !reg_addr)) |=> sts[1]);              // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en != 2'b00));                                      // R11
  AST_IRQ_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != 2'b00));                                     // R11
endmodule

bind txpkt_fifo_abort txpkt_fifo_abort_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_pull(tx_pull), .tx_valid(tx_valid),
  .tx_abort(tx_abort), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .sts(sts_q), .en(en_q)
);

// File: tb/txpkt_fifo_abort_test.sv
module txpkt_fifo_abort_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid, wr_par, wr_sop, wr_eop, wr_full;
  logic [7:0] wr_data, tx_data, reg_wdata, reg_rdata;
  logic tx_pull, tx_valid, tx_sop, tx_eop, tx_abort;
  logic reg_rd, reg_wr, reg_addr, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txpkt_fifo_abort #(.DEPTH(DEPTH), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_par(wr_par), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_full(wr_full),
    .tx_pull(tx_pull), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_abort(tx_abort),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input bit s, input bit e, input bit bad);
    wr_valid = 1'b1; wr_data = d; wr_par = ~(^d) ^ bad; wr_sop = s; wr_eop = e;
    step();
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
  endtask

  task automatic pull();
    tx_pull = 1'b1; step(); tx_pull = 1'b0;
  endtask

  task automatic pull_chk(input bit v, input logic [7:0] d, input bit s, input bit e,
                          input bit a, input string tag);
    logic [11:0] act, exp;
    pull();
    act = {tx_valid, tx_abort, tx_sop, tx_eop, tx_data};
    exp = {v, a, s, e, d};
    chk(act == exp, tag, 32'(act), 32'(exp));
  endtask

  task automatic rd(input bit a, output logic [7:0] v);
    reg_rd = 1'b1; reg_addr = a; step(); reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic regw(input bit a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; step(); reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr_valid = 0; wr_data = 0; wr_par = 0; wr_sop = 0; wr_eop = 0;
    tx_pull = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    chk({tx_valid, tx_abort, irq, wr_full} == 4'b0, "R1 outputs", {tx_valid, tx_abort, irq, wr_full}, 0);
    rd(0, v); chk(v == 8'h00, "R1 status", v, 0);
    rd(1, v); chk(v == 8'h00, "R1 enable", v, 0);
    pull_chk(0, 0, 0, 0, 0, "R1 empty");

    // R2: every packet length up to DEPTH
    for (int len = 1; len <= DEPTH; len++) begin
      for (int i = 0; i < len; i++) wr(8'(len*16 + i), i == 0, i == len-1, 0);
      chk(!tx_valid, "R12 no pull", tx_valid, 0);
      for (int i = 0; i < len; i++)
        pull_chk(1, 8'(len*16 + i), i == 0, i == len-1, 0, "R2 order");
      pull_chk(0, 0, 0, 0, 0, "R4 closed empty pull");
    end

    // R3: overfill by two
    for (int i = 0; i < DEPTH + 2; i++) wr(8'(8'hA0 + i), i == 0, i == DEPTH-1, 0);
    chk(wr_full, "R3 full flag", wr_full, 1);
    for (int i = 0; i < DEPTH; i++)
      pull_chk(1, 8'(8'hA0 + i), i == 0, i == DEPTH-1, 0, "R3 kept bytes");
    pull_chk(0, 0, 0, 0, 0, "R3 overflow dropped");

    // R4 R5 R6: underflow mid packet
    wr(8'h11, 1, 0, 0); wr(8'h12, 0, 0, 0);
    pull_chk(1, 8'h11, 1, 0, 0, "R2");
    pull_chk(1, 8'h12, 0, 0, 0, "R2");
    pull_chk(0, 0, 0, 0, 1, "R4 abort");
    wr(8'h13, 0, 0, 0); wr(8'h14, 0, 1, 0);
    wr(8'h15, 1, 1, 0);
    pull_chk(1, 8'h15, 1, 1, 0, "R6 next packet");
    pull_chk(0, 0, 0, 0, 0, "R5 remainder discarded");
    rd(0, v); chk(v == 8'h02, "R8 underflow bit", v, 8'h02);
    rd(0, v); chk(v == 8'h00, "R8 cleared by read", v, 0);

    // R5: write in the underflow cycle itself is discarded
    wr(8'h21, 1, 0, 0);
    pull_chk(1, 8'h21, 1, 0, 0, "R2");
    tx_pull = 1; wr_valid = 1; wr_data = 8'h22; wr_par = ~(^8'h22);
    step(); tx_pull = 0; wr_valid = 0;
    chk(tx_abort && !tx_valid, "R5 collision abort", {tx_valid, tx_abort}, 2'b01);
    wr(8'h23, 0, 1, 0); wr(8'h24, 1, 1, 0);
    pull_chk(1, 8'h24, 1, 1, 0, "R5 same-cycle byte gone");
    pull_chk(0, 0, 0, 0, 0, "R6 idle");
    rd(0, v);

    // R7: full parity sweep
    for (int d = 0; d < 256; d++) begin
      for (int p = 0; p < 2; p++) begin
        wr_valid = 1; wr_data = 8'(d); wr_par = p[0]; step(); wr_valid = 0;
        rd(0, v);
        chk(v[0] == ~(^{8'(d), p[0]}), "R7 parity", v, {7'b0, ~(^{8'(d), p[0]})});
      end
    end
    repeat (DEPTH) pull();

    // R8 R10: register access
    regw(0, 8'hFF); rd(0, v); chk(v == 8'h00, "R8 status not writable", v, 0);
    regw(1, 8'hFF); rd(1, v); chk(v == 8'h03, "R10 enable mask", v, 8'h03);

    // R11: sweep of status and enable combinations
    for (int s = 1; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        regw(1, 8'(e));
        rd(0, v);
        if (s[1]) begin
          wr(8'h31, 1, 0, 0); pull(); pull();
          wr(8'h32, 0, 1, s[0]);
        end else begin
          wr(8'h33, 0, 0, 1); pull();
        end
        chk(irq == ((s & e) != 0), "R11 irq", irq, (s & e) != 0);
        rd(1, v); chk(v == 8'(e), "R10 readback", v, e);
        rd(0, v); chk(v == 8'(s), "R8 status value", v, s);
        chk(!irq, "R11 irq after clear", irq, 0);
      end
    end
    regw(1, 8'h00);

    // R9: events coincident with status read
    wr_valid = 1; wr_data = 8'h40; wr_par = ^8'h40; reg_rd = 1; reg_addr = 0;
    step(); wr_valid = 0; reg_rd = 0;
    chk(reg_rdata == 8'h00, "R9 parity read old", reg_rdata, 0);
    pull();
    rd(0, v); chk(v == 8'h01, "R9 parity kept", v, 1);
    wr(8'h41, 1, 0, 0); pull();
    tx_pull = 1; reg_rd = 1; reg_addr = 0; step(); tx_pull = 0; reg_rd = 0;
    chk(reg_rdata == 8'h00 && tx_abort, "R9 underflow read old", {tx_abort, reg_rdata}, 9'h100);
    rd(0, v); chk(v == 8'h02, "R9 underflow kept", v, 2);
    wr(8'h42, 0, 1, 0);
    pull_chk(0, 0, 0, 0, 0, "R5 end discarded");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule